// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns one asynchronous serial line into parallel characters. A local sample clock runs at 1, 16 or 64 times the bit rate. The block waits for the line to fall from its idle high level. In the oversampled ratios it waits half a bit time and confirms the start bit. It then samples every later bit once per bit time, at its centre. In the 1x ratio the clock edges are taken to be aligned with bit centres already, so each bit is read on a single edge.

The character format is chosen by three inputs: the data length (7 or 8 bits), the parity mode (none, even or odd) and the stop-bit count (one or two). Together these give twelve formats. The ratio and the format are captured when a start edge is accepted and stay fixed until that character is done. When the last stop bit has been sampled, the block raises a one-cycle strobe. On the same clock edge it updates the data byte and the framing and parity flags, and these outputs then hold until the next character completes.

Top module: `osr_receiver`

## Requirements
- R1: While reset is low and after it is released with no traffic, `rx_valid`, `frame_err`, `parity_err` and `rx_data` are all 0.
- R2: In the 16x and 64x ratios (N clocks per bit), the receiver arms on a clock edge E that sees the line at 0 after it was 1 on the previous edge. Bit k of the frame (start = 0) is sampled on edge E + N/2 + k·N. `rx_valid` is high for the cycle after the edge that samples the last stop bit.
- R3: If the line reads 1 at the half-bit check of the start bit, the receiver returns to idle and produces no strobe. A later valid character is still received.
- R4: `ratio_sel` encoding: 00 = 1x, 01 = 16x, 10 = 64x, 11 = 64x. In 1x mode, bit k of the frame is sampled on edge E + k. There is no half-bit delay.
- R5: Data bits arrive least significant bit first. For a 7-bit character, `rx_data[7]` is 0.
- R6: Format encoding: `len8` = 1 selects 8 data bits and 0 selects 7. `parity_sel` 00 or 11 means no parity bit, 01 means even parity and 10 means odd parity. `two_stop` = 1 expects two stop bits. Every combination is received correctly.
- R7: `parity_err` is 1 when the count of ones in the data bits plus the parity bit is odd in even mode, or even in odd mode. With no parity selected it is 0.
- R8: `frame_err` is 1 when any stop bit of the character reads 0, and 0 otherwise. Each completed character overwrites it.
- R9: `rx_valid` lasts exactly one cycle per received character. `rx_data`, `frame_err` and `parity_err` change only on the edge that raises it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock at 1, 16 or 64 times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial input, idle high, synchronous to clk |
| ratio_sel | input | 2 | Clocks per bit: 00 1x, 01 16x, 1x 64x |
| len8 | input | 1 | 1: eight data bits, 0: seven |
| parity_sel | input | 2 | 00/11 none, 01 even, 10 odd |
| two_stop | input | 1 | 1: two stop bits expected |
| rx_data | output | 8 | Last received character, LSB first on the line |
| rx_valid | output | 1 | One-cycle strobe when a character completes |
| frame_err | output | 1 | A stop bit of the last character read 0 |
| parity_err | output | 1 | Parity of the last character did not match the mode |

## Verification
Every result of a character falls in one cycle. That cycle comes after edge E + D, where D = N/2 + K·N for the oversampled ratios and D = K for 1x. E is the edge that first sees the start bit, and K is the index of the last stop bit in the frame. The bench counts rising edges and drives the line on falling edges. It records the edge count at which the start bit goes out, and it records the edge count at which a falling-edge monitor first sees the strobe. It checks that the second count equals the first plus 1 + D, and that exactly one strobe appeared in the character's window. Data and flags are captured by the same monitor during the strobe cycle, so each value is compared in the one cycle in which it is due.

// File: rtl/osr_pkg.sv
package osr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } rx_state_e;

  typedef struct packed {
    logic [1:0] ratio;
    logic       len8;
    logic [1:0] par;
    logic       two_stop;
  } rx_fmt_t;

  // clocks per bit for a ratio select code
  function automatic int unsigned ratio_of(input logic [1:0] sel,
                                           input int unsigned mid,
                                           input int unsigned high);
    case (sel)
      2'b00:   return 1;
      2'b01:   return mid;
      default: return high;
    endcase
  endfunction

  function automatic logic parity_used(input logic [1:0] mode);
    return (mode == 2'b01) || (mode == 2'b10);
  endfunction

  // 1 when received parity disagrees with the selected mode
  function automatic logic parity_bad(input logic [7:0] d, input logic len8,
                                      input logic pbit, input logic [1:0] mode);
    logic ones;
    ones = len8 ? ^d : ^d[6:0];
    case (mode)
      2'b01:   return ones ^ pbit;
      2'b10:   return ~(ones ^ pbit);
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/osr_fall_detect.sv
module osr_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic line,
  output logic fall
);
  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= line;
  end

  assign fall = prev & ~line;
endmodule

// File: rtl/osr_bit_timer.sv
module osr_bit_timer #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          load_en,
  input  logic [CW-1:0] load_val,
  output logic          tick
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt <= '0;
    else if (load_en)       cnt <= load_val;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign tick = active && (cnt == '0);

  // counter takes the reload value the cycle after a load
  assert_reload_taken_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (cnt == $past(load_val)));
endmodule

// File: rtl/osr_framer.sv
module osr_framer
  import osr_pkg::*;
#(
  parameter int MID_RATIO  = 16,
  parameter int HIGH_RATIO = 64,
  parameter int CW         = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          fall,
  input  logic          tick,
  input  rx_fmt_t       fmt_in,
  output logic          active,
  output logic          load_en,
  output logic [CW-1:0] load_val,
  output logic [7:0]    rx_data,
  output logic          rx_valid,
  output logic          frame_err,
  output logic          parity_err
);
  rx_state_e   state;
  rx_fmt_t     fmt_q;
  logic [7:0]  shreg;
  logic [2:0]  bit_idx;
  logic        stop_idx;
  logic        pbit;
  logic        stop_bad;

  int unsigned n_now, n_q;
  logic start_ev, last_data, last_stop, noise_ev, frame_done;

  always_comb begin
    n_now      = ratio_of(fmt_in.ratio, MID_RATIO, HIGH_RATIO);
    n_q        = ratio_of(fmt_q.ratio, MID_RATIO, HIGH_RATIO);
    start_ev   = (state == ST_IDLE) && fall;
    last_data  = bit_idx == (fmt_q.len8 ? 3'd7 : 3'd6);
    last_stop  = stop_idx == fmt_q.two_stop;
    noise_ev   = tick && (state == ST_START) && rx_line;
    frame_done = tick && (state == ST_STOP) && last_stop;
    load_en    = start_ev || tick;
    if (start_ev) load_val = (n_now == 1) ? '0 : CW'(n_now / 2 - 1);
    else          load_val = CW'(n_q - 1);
    active     = state != ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      fmt_q      <= '0;
      shreg      <= '0;
      bit_idx    <= '0;
      stop_idx   <= 1'b0;
      pbit       <= 1'b0;
      stop_bad   <= 1'b0;
      rx_data    <= '0;
      rx_valid   <= 1'b0;
      frame_err  <= 1'b0;
      parity_err <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (state)
        ST_IDLE: if (fall) begin
          fmt_q    <= fmt_in;
          shreg    <= '0;
          bit_idx  <= '0;
          stop_idx <= 1'b0;
          pbit     <= 1'b0;
          stop_bad <= 1'b0;
          state    <= (n_now == 1) ? ST_DATA : ST_START;
        end
        ST_START: if (tick) state <= rx_line ? ST_IDLE : ST_DATA;
        ST_DATA: if (tick) begin
          shreg[bit_idx] <= rx_line;
          bit_idx        <= bit_idx + 3'd1;
          if (last_data) state <= parity_used(fmt_q.par) ? ST_PAR : ST_STOP;
        end
        ST_PAR: if (tick) begin
          pbit  <= rx_line;
          state <= ST_STOP;
        end
        ST_STOP: if (tick) begin
          if (!rx_line) stop_bad <= 1'b1;
          if (last_stop) begin
            state      <= ST_IDLE;
            rx_valid   <= 1'b1;
            rx_data    <= shreg;
            frame_err  <= stop_bad | ~rx_line;
            parity_err <= parity_bad(shreg, fmt_q.len8, pbit, fmt_q.par);
          end else begin
            stop_idx <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_strobe_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_outputs_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(frame_err) && $stable(parity_err)));

  assert_seven_bit_msb_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !fmt_q.len8) |-> (rx_data[7] == 1'b0));

  assert_no_parity_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !parity_used(fmt_q.par)) |-> !parity_err);

  assert_noise_abort_R3: assert property (@(posedge clk) disable iff (!rst_n)
    noise_ev |=> ((state == ST_IDLE) && !rx_valid));

  assert_unit_ratio_every_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && (n_q == 1)) |-> tick);

  assert_done_strobes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> rx_valid);
endmodule

// File: rtl/osr_receiver.sv
module osr_receiver
  import osr_pkg::*;
#(
  parameter int MID_RATIO  = 16,
  parameter int HIGH_RATIO = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_line,
  input  logic [1:0] ratio_sel,
  input  logic       len8,
  input  logic [1:0] parity_sel,
  input  logic       two_stop,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  output logic       frame_err,
  output logic       parity_err
);
  localparam int CW = $clog2(HIGH_RATIO);

  rx_fmt_t       fmt_in;
  logic          fall, tick, active, load_en;
  logic [CW-1:0] load_val;

  assign fmt_in = '{ratio: ratio_sel, len8: len8, par: parity_sel, two_stop: two_stop};

  osr_fall_detect i_fall (
    .clk(clk), .rst_n(rst_n), .line(rx_line), .fall(fall)
  );

  osr_bit_timer #(.CW(CW)) i_timer (
    .clk(clk), .rst_n(rst_n), .active(active),
    .load_en(load_en), .load_val(load_val), .tick(tick)
  );

  osr_framer #(.MID_RATIO(MID_RATIO), .HIGH_RATIO(HIGH_RATIO), .CW(CW)) i_framer (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .fall(fall), .tick(tick),
    .fmt_in(fmt_in), .active(active), .load_en(load_en), .load_val(load_val),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err)
  );
endmodule

// File: tb/test_osr_receiver.sv
`timescale 1ns/1ps
module test_osr_receiver;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [1:0] ratio_sel = 2'b01;
  logic       len8 = 1'b1;
  logic [1:0] parity_sel = 2'b00;
  logic       two_stop = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, frame_err, parity_err;

  int n_checks = 0;
  int n_fail = 0;
  int cyc = 0;
  int valid_cnt = 0;
  int valid_cyc = -1;
  logic [7:0] cap_data = '0;
  logic cap_fe = 1'b0, cap_pe = 1'b0;

  always #2.5 clk = ~clk;

  osr_receiver i_osr_receiver (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .ratio_sel(ratio_sel),
    .len8(len8), .parity_sel(parity_sel), .two_stop(two_stop),
    .rx_data(rx_data), .rx_valid(rx_valid), .frame_err(frame_err),
    .parity_err(parity_err)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      valid_cnt = valid_cnt + 1;
      if (valid_cnt == 1) valid_cyc = cyc;
      cap_data = rx_data;
      cap_fe   = frame_err;
      cap_pe   = parity_err;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  function automatic logic [1:0] sel_for(input int n);
    if (n == 1) return 2'b00;
    if (n == 16) return 2'b01;
    return 2'b10;
  endfunction

  // sends one frame and checks strobe count, timing, data and both flags
  task automatic run_frame(input int n, input logic [1:0] rsel, input logic [7:0] d,
                           input bit l8, input logic [1:0] par, input bit two,
                           input bit flip_par, input bit s1, input bit s2,
                           input string ttag, input string dtag);
    int start_cyc, nbits, k_last, due;
    bit has_par, ones;
    logic [7:0] exp_d;
    nbits   = l8 ? 8 : 7;
    has_par = (par == 2'b01) || (par == 2'b10);
    ones = 1'b0;
    for (int i = 0; i < nbits; i++) ones ^= d[i];
    valid_cnt = 0;
    valid_cyc = -1;
    @(negedge clk);
    ratio_sel = rsel; len8 = l8; parity_sel = par; two_stop = two;
    rx_line = 1'b0;
    start_cyc = cyc;
    repeat (n) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rx_line = d[i];
      repeat (n) @(negedge clk);
    end
    if (has_par) begin
      rx_line = ((par == 2'b01) ? ones : ~ones) ^ flip_par;
      repeat (n) @(negedge clk);
    end
    rx_line = s1;
    repeat (n) @(negedge clk);
    if (two) begin
      rx_line = s2;
      repeat (n) @(negedge clk);
    end
    rx_line = 1'b1;
    repeat (2 * n + 4) @(negedge clk);
    k_last = nbits + (has_par ? 1 : 0) + (two ? 2 : 1);
    due    = (n == 1) ? k_last : (n / 2 + k_last * n);
    exp_d  = l8 ? d : {1'b0, d[6:0]};
    check(valid_cnt == 1, "R9 one strobe per character", valid_cnt, 1);
    check(valid_cyc == start_cyc + 1 + due, {ttag, " strobe cycle"}, valid_cyc, start_cyc + 1 + due);
    check(cap_data == exp_d, {dtag, " data byte"}, cap_data, exp_d);
    check(cap_pe == (flip_par && has_par), "R7 parity flag", cap_pe, flip_par && has_par);
    check(cap_fe == !(s1 && (!two || s2)), "R8 framing flag", cap_fe, !(s1 && (!two || s2)));
  endtask

  task automatic t_reset();
    repeat (4) @(negedge clk);
    check(!rx_valid && !frame_err && !parity_err && rx_data == 0, "R1 outputs in reset", rx_data, 0);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    check(!rx_valid, "R1 no strobe when idle", rx_valid, 0);
    check(!frame_err && !parity_err, "R1 flags clear", {frame_err, parity_err}, 0);
    check(rx_data == 0, "R1 data clear", rx_data, 0);
  endtask

  task automatic t_basic16();  // R2 R5: 8N1 at 16x
    run_frame(16, 2'b01, 8'hA5, 1, 2'b00, 0, 0, 1, 1, "R2", "R5");
    run_frame(16, 2'b01, 8'h3C, 1, 2'b00, 0, 0, 1, 1, "R2", "R5");
  endtask

  task automatic t_seven64();  // R5 R6: 7 even 1 at 64x, MSB forced to zero
    run_frame(64, 2'b10, 8'hD5, 0, 2'b01, 0, 0, 1, 1, "R2", "R5");
  endtask

  task automatic t_odd_two_stop();  // R6: 8 odd 2 and 7 none 2
    run_frame(16, 2'b01, 8'h81, 1, 2'b10, 1'b1, 0, 1, 1, "R2", "R6");
    run_frame(16, 2'b01, 8'h4E, 0, 2'b11, 1'b1, 0, 1, 1, "R2", "R6");
  endtask

  task automatic t_parity_err();  // R7
    run_frame(16, 2'b01, 8'h0F, 1, 2'b01, 0, 1, 1, 1, "R2", "R5");
    run_frame(16, 2'b01, 8'h12, 0, 2'b10, 0, 1, 1, 1, "R2", "R6");
  endtask

  task automatic t_framing();  // R8: bad stop then a clean character clears it
    run_frame(16, 2'b01, 8'h77, 1, 2'b00, 0, 0, 0, 1, "R2", "R5");
    run_frame(16, 2'b01, 8'h11, 1, 2'b00, 0, 0, 1, 1, "R2", "R5");
    run_frame(16, 2'b01, 8'h22, 1, 2'b01, 1, 0, 1, 0, "R2", "R6");
  endtask

  task automatic t_unit_ratio();  // R4: 1x, no half-bit delay
    run_frame(1, 2'b00, 8'hC3, 1, 2'b00, 0, 0, 1, 1, "R4", "R5");
    run_frame(1, 2'b00, 8'h5A, 0, 2'b10, 1, 0, 1, 1, "R4", "R6");
    run_frame(64, 2'b11, 8'h96, 1, 2'b01, 0, 0, 1, 1, "R4", "R6");
  endtask

  task automatic t_noise();  // R3: short low pulse rejected
    valid_cnt = 0;
    @(negedge clk);
    ratio_sel = 2'b01; len8 = 1; parity_sel = 2'b00; two_stop = 0;
    rx_line = 1'b0;
    repeat (3) @(negedge clk);
    rx_line = 1'b1;
    repeat (16 * 12) @(negedge clk);
    check(valid_cnt == 0, "R3 glitch gives no strobe", valid_cnt, 0);
    run_frame(16, 2'b01, 8'hE7, 1, 2'b00, 0, 0, 1, 1, "R3", "R3");
  endtask

  initial begin
    t_reset();
    t_basic16();
    t_seven64();
    t_odd_two_stop();
    t_parity_err();
    t_framing();
    t_unit_ratio();
    t_noise();
    finish_run();
  end

  initial begin
    #(150000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end
endmodule